// File: doc/BRIEF.md
# Asynchronous byte-wide SRAM bus controller

This block is a synchronous master for an asynchronous static memory with a 17-bit address and an 8-bit data path. A requester presents an address, a write flag and write data under a valid/ready handshake. The controller then produces the memory's chip-enable, output-enable and write-enable strobes, all active low, with cycle-accurate spacing. A read returns its byte with a one-cycle response pulse.

Every timing limit of the memory is a parameter in nanoseconds, next to the clock period. At elaboration each limit is rounded up to whole clock cycles, so the same design serves the 70, 85 and 120 ns speed grades. Writes are controlled by write-enable. Chip-enable is lowered one cycle ahead, output-enable stays high for the whole write, and the data driver is enabled only while write-enable is low. A protect input forces the memory interface idle during a supply fault.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, mem_ce_n, mem_oe_n and mem_we_n are 1, mem_dq_oe and rsp_valid are 0, and req_ready is 1 once reset is released with protect low.
- R2: A read holds mem_ce_n and mem_oe_n at 0 and mem_we_n at 1 for exactly RD cycles. RD is the larger of two values: the ceiling of the slowest of the address, chip-enable and output-enable access times over the clock period, and the read-cycle ceiling minus GAP. RD is 7 at the defaults.
- R3: rsp_valid is a single-cycle pulse in the cycle after the last read cycle. rsp_rdata carries the byte present on mem_dq_i at the end of that last cycle, so the response appears RD+1 cycles after the accepting edge.
- R4: A write lowers mem_ce_n one cycle before mem_we_n falls. mem_we_n stays at 0 for exactly WP cycles, where WP is the largest of the pulse-width ceiling, the data-setup ceiling and the write-cycle ceiling minus (2+GAP). mem_oe_n is 1 whenever mem_we_n is 0. WP is 6 at the defaults.
- R5: mem_dq_oe is 1 only while mem_we_n and mem_ce_n are both 0, and is 1 for the whole write pulse. mem_dq_o carries the accepted write byte, which is the byte a later read of that address returns.
- R6: mem_addr does not change while mem_ce_n stays 0. After mem_we_n rises, mem_ce_n stays 0 for HOLD = max(1, ceil(write-enable address hold)) cycles, which is 1 at the defaults.
- R7: Between two memory cycles mem_ce_n stays 1 for at least GAP = max(1, ceil(chip-enable address hold)) cycles, which is 2 at the defaults. req_ready returns 1 exactly 2+WP+HOLD+GAP cycles after a write is accepted.
- R8: While protect is 1, mem_ce_n, mem_oe_n and mem_we_n are 1, mem_dq_oe is 0 and req_ready is 0. A request held during protect is accepted after protect falls and is then carried out normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| protect | input | 1 | Supply-fault protect; forces the memory interface idle |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Request byte address |
| req_wdata | input | DW | Write byte |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | DW | Read byte |
| mem_addr | output | AW | Memory address |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_dq_o | output | DW | Data toward the memory |
| mem_dq_oe | output | 1 | Enable for the data bus driver |
| mem_dq_i | input | DW | Data from the memory |

## Verification
Each interval in the controller is timed by a single down-counter in a single state register, so an internal fault shows up directly as a strobe run of the wrong length. An off-by-one load appears as a short or long write pulse, or a short read window, within the first memory cycle. A too-early read sample returns the memory model's filler byte instead of the stored data. A state that fails to return to idle shows as req_ready staying low past its exact expected cycle. A broken protect path shows in the same cycle as an active strobe or a raised ready.

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl #(
  parameter int AW     = 17,
  parameter int DW     = 8,
  parameter int CLK_NS = 10,
  parameter int T_AA   = 70,
  parameter int T_ACE  = 70,
  parameter int T_AOE  = 35,
  parameter int T_RC   = 70,
  parameter int T_WC   = 70,
  parameter int T_WPW  = 55,
  parameter int T_DSU  = 30,
  parameter int T_WAH  = 5,
  parameter int T_CAH  = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          protect,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic [DW-1:0] mem_dq_o,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_i
);

  function automatic int cyc(input int ns);
    return (ns + CLK_NS - 1) / CLK_NS;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int ACC_NS = imax(T_AA, imax(T_ACE, T_AOE));
  localparam int GAP_C  = imax(1, cyc(T_CAH));
  localparam int HOLD_C = imax(1, cyc(T_WAH));
  localparam int RD_C   = imax(cyc(ACC_NS), cyc(T_RC) - GAP_C);
  localparam int WP_C   = imax(imax(cyc(T_WPW), cyc(T_DSU)), cyc(T_WC) - 1 - HOLD_C - GAP_C);
  localparam int MAX_C  = imax(imax(RD_C, WP_C), imax(GAP_C, HOLD_C));
  localparam int CW     = $clog2(MAX_C + 1);

  typedef enum logic [2:0] {S_IDLE, S_READ, S_WSET, S_WPUL, S_WHLD, S_GAP} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic [DW-1:0] rdata_q;
  logic          rsp_q;
  logic          ce_on;
  logic          accept;
  logic          done;

  assign req_ready = (st == S_IDLE) && !protect;
  assign accept    = req_valid && req_ready;
  assign done      = (cnt == '0);
  assign ce_on     = (st == S_READ) || (st == S_WSET) || (st == S_WPUL) || (st == S_WHLD);

  assign mem_addr  = addr_q;
  assign mem_dq_o  = wdata_q;
  assign mem_ce_n  = !ce_on || protect;
  assign mem_oe_n  = (st != S_READ) || protect;
  assign mem_we_n  = (st != S_WPUL) || protect;
  assign mem_dq_oe = (st == S_WPUL) && !protect;
  assign rsp_valid = rsp_q;
  assign rsp_rdata = rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      rsp_q   <= 1'b0;
    end else begin
      rsp_q <= 1'b0;
      if (!done) cnt <= cnt - 1'b1;
      unique case (st)
        S_IDLE: if (accept) begin
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          if (req_write) begin
            st  <= S_WSET;
            cnt <= '0;
          end else begin
            st  <= S_READ;
            cnt <= CW'(RD_C - 1);
          end
        end
        S_READ: if (done) begin
          rdata_q <= mem_dq_i;
          rsp_q   <= 1'b1;
          st      <= S_GAP;
          cnt     <= CW'(GAP_C - 1);
        end
        S_WSET: begin
          st  <= S_WPUL;
          cnt <= CW'(WP_C - 1);
        end
        S_WPUL: if (done) begin
          st  <= S_WHLD;
          cnt <= CW'(HOLD_C - 1);
        end
        S_WHLD: if (done) begin
          st  <= S_GAP;
          cnt <= CW'(GAP_C - 1);
        end
        S_GAP: if (done) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_OE_HIGH_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n); // R4

  AST_DRIVE_IN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (!mem_we_n && !mem_ce_n)); // R5

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr)); // R6

  AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(st) == S_READ)); // R3

  AST_PROTECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    protect |-> (mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && !req_ready)); // R8

  AST_SINGLE_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R3

endmodule

// File: tb/tb_sram_async_ctrl.sv
module tb_sram_async_ctrl;
  localparam int CK      = 10;
  localparam int EXP_RD  = (70 + CK - 1) / CK;
  localparam int EXP_WP  = (55 + CK - 1) / CK;
  localparam int EXP_WH  = 1;
  localparam int EXP_GAP = (15 + CK - 1) / CK;
  localparam int W_BUSY  = 2 + EXP_WP + EXP_WH + EXP_GAP;
  localparam int R_LAT   = EXP_RD + 1;

  logic clk = 1'b0, rst_n = 1'b0, protect = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic req_ready, rsp_valid, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [7:0] rsp_rdata, mem_dq_o;
  logic [7:0] mem_dq_i = 8'h5A;
  logic [16:0] mem_addr;

  int checks = 0, fails = 0, mchecks = 0, mfails = 0;

  always #(CK/2) clk = ~clk;

  sram_async_ctrl dut (
    .clk(clk), .rst_n(rst_n), .protect(protect),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  // memory model and strobe monitor
  logic [7:0] mem [int];
  logic prev_act = 0, prev_we = 1, prev_ce = 1, spoil = 1;
  logic [16:0] prev_addr = '0, wl_addr = '0;
  logic [7:0]  wl_data = '0;
  int wl_cnt = 0, hold_cnt = 0, rd_run = 0, gap_cnt = 100, rd_cnt = 0;
  logic in_hold = 0;

  task automatic mcheck(input bit ok, input string rq, input int act, input int exp);
    mchecks++;
    if (!ok) begin
      mfails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", rq, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin : monitor
    logic act, bad, rd;
    act = !mem_ce_n && !mem_we_n;
    bad = spoil || protect || !rst_n;
    rd  = !mem_ce_n && !mem_oe_n && mem_we_n;
    if (act) begin
      wl_addr <= mem_addr;
      wl_data <= mem_dq_o;
      mcheck(mem_dq_oe, "R5 driver on during pulse", mem_dq_oe, 1);
      mcheck(mem_oe_n, "R4 oe high during write", mem_oe_n, 1);
    end
    if (mem_dq_oe && mem_we_n) mcheck(0, "R5 driver outside pulse", 1, 0);
    if (prev_act && !act) mem[int'(wl_addr)] = wl_data;
    if (!mem_we_n) wl_cnt <= wl_cnt + 1;
    if (prev_we && !mem_we_n && !bad) mcheck(!prev_ce, "R4 ce before we", prev_ce, 0);
    if (!prev_we && mem_we_n) begin
      if (!bad) mcheck(wl_cnt == EXP_WP, "R4 we pulse width", wl_cnt, EXP_WP);
      wl_cnt <= 0;
      in_hold <= 1'b1;
      hold_cnt <= mem_ce_n ? 0 : 1;
    end else if (in_hold) begin
      if (mem_ce_n) begin
        if (!bad) mcheck(hold_cnt == EXP_WH, "R6 ce hold after we", hold_cnt, EXP_WH);
        in_hold <= 1'b0;
      end else hold_cnt <= hold_cnt + 1;
    end
    if (rd) rd_run <= rd_run + 1;
    else if (rd_run != 0) begin
      if (!bad) mcheck(rd_run == EXP_RD, "R2 read window", rd_run, EXP_RD);
      rd_run <= 0;
    end
    if (!mem_ce_n && !prev_ce && !bad)
      mcheck(mem_addr == prev_addr, "R6 address stable", mem_addr, prev_addr);
    if (mem_ce_n) gap_cnt <= gap_cnt + 1;
    else begin
      if (prev_ce && !bad) mcheck(gap_cnt >= EXP_GAP, "R7 ce gap", gap_cnt, EXP_GAP);
      gap_cnt <= 0;
    end
    if (rd) begin
      if (rd_cnt + 1 >= EXP_RD)
        mem_dq_i <= mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 8'h00;
      else mem_dq_i <= 8'h5A;
      rd_cnt <= rd_cnt + 1;
    end else begin
      mem_dq_i <= 8'h5A;
      rd_cnt <= 0;
    end
    spoil     <= (protect || !rst_n) ? 1'b1 : (req_ready ? 1'b0 : spoil);
    prev_act  <= act;
    prev_we   <= mem_we_n;
    prev_ce   <= mem_ce_n;
    prev_addr <= mem_addr;
  end

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", rq, act, exp, $time);
    end
  endtask

  task automatic idle_pins(input string rq);
    check(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe,
          rq, {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}, 4'b1110);
  endtask

  task automatic issue(input bit wr, input logic [16:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (req_ready) break;
    end
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  task automatic do_req(input bit wr, input logic [16:0] a, input logic [7:0] d);
    int lat;
    issue(wr, a, d);
    lat = 0;
    if (wr) begin
      do begin @(negedge clk); lat++; end while (!req_ready && lat < 100);
      check(lat == W_BUSY, "R7 write busy cycles", lat, W_BUSY);
    end else begin
      do begin @(negedge clk); lat++; end while (!rsp_valid && lat < 100);
      check(lat == R_LAT, "R3 read latency", lat, R_LAT);
      check(rsp_rdata == d, "R3 read data", rsp_rdata, d);
      @(negedge clk);
      check(!rsp_valid, "R3 single pulse", rsp_valid, 0);
      while (!req_ready) @(negedge clk);
    end
  endtask

  localparam logic [25:0] VEC [0:11] = '{
    {1'b1, 17'h00000, 8'h3C}, {1'b1, 17'h1FFFF, 8'hC3}, {1'b1, 17'h0AAAA, 8'h55},
    {1'b1, 17'h15555, 8'hAA}, {1'b0, 17'h00000, 8'h3C}, {1'b0, 17'h1FFFF, 8'hC3},
    {1'b1, 17'h0AAAA, 8'h0F}, {1'b0, 17'h0AAAA, 8'h0F}, {1'b0, 17'h15555, 8'hAA},
    {1'b1, 17'h00001, 8'hFF}, {1'b0, 17'h00001, 8'hFF}, {1'b0, 17'h00000, 8'h3C}
  };

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks + mchecks, fails + mfails);
    $finish;
  end

  initial begin : main
    int n;
    repeat (3) @(negedge clk);
    idle_pins("R1 strobes idle in reset");
    check(!rsp_valid, "R1 no response in reset", rsp_valid, 0);
    @(posedge clk); #1 rst_n = 1;
    @(negedge clk);
    idle_pins("R1 strobes idle after reset");
    check(req_ready, "R1 ready after reset", req_ready, 1);

    for (int i = 0; i < 12; i++) do_req(VEC[i][25], VEC[i][24:8], VEC[i][7:0]);

    // R8: request held during protect
    @(posedge clk); #1;
    protect = 1; req_valid = 1; req_write = 1; req_addr = 17'h00002; req_wdata = 8'h77;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      idle_pins("R8 strobes idle under protect");
      check(!req_ready, "R8 ready low under protect", req_ready, 0);
    end
    @(posedge clk); #1 protect = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (req_ready) break;
    end
    @(posedge clk); #1 req_valid = 0;
    while (!req_ready) @(negedge clk);
    do_req(0, 17'h00002, 8'h77); // R8 held write carried out

    // R8: protect in the middle of a read
    issue(0, 17'h00000, 8'h00);
    repeat (2) @(negedge clk);
    @(posedge clk); #1 protect = 1;
    @(negedge clk);
    idle_pins("R8 read strobes drop under protect");
    @(posedge clk); #1 protect = 0;
    n = 0;
    while (!req_ready && n < 100) begin @(negedge clk); n++; end
    check(req_ready, "R8 recovers after protect", req_ready, 1);

    // R1: reset in the middle of a write pulse
    issue(1, 17'h00003, 8'h99);
    repeat (3) @(negedge clk);
    @(posedge clk); #1 rst_n = 0;
    @(negedge clk);
    idle_pins("R1 strobes idle on reset mid-write");
    @(posedge clk); #1 rst_n = 1;
    @(negedge clk);
    check(req_ready, "R1 ready after mid-write reset", req_ready, 1);

    do_req(1, 17'h00004, 8'h21); // R5 data path after reset
    do_req(0, 17'h00004, 8'h21);

    repeat (5) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks + mchecks, fails + mfails);
    $finish;
  end
endmodule